// File: doc/BRIEF.md
# Graphics Command Packet Unpacker

This block sits between a quadword stream and a register file of a drawing engine. Every packet starts with a 128-bit header quadword. The header sets a loop count, an end-of-packet mark, an optional primitive value, a data mode, a descriptor count, and up to sixteen 4-bit descriptors. In packed mode, each data quadword after the header is read through the current descriptor. The descriptor picks the target register and the way the quadword's fields are repacked into a 64-bit register value. The block then emits one register write of an 8-bit address and 64-bit data, or no write at all.

Input quadwords use a valid/ready handshake. The write port has its own valid/ready pair, and a stalled write holds the input back. Besides each write, the block drives a flag that marks vertex writes that must not start drawing. It also gives a one-cycle pulse when a packet with the end mark completes, and a one-cycle pulse when a header names a mode other than packed. For any mode other than packed, the following quadwords are dropped.

Top module: `gcp_unpacker`

## Requirements
- R1: While reset is applied, in_ready, wr_valid, pkt_done and mode_unsup are all 0, and a presented quadword is not consumed.
- R2: The header is decoded as follows:
  - bits 14:0 are the loop count;
  - bit 15 is the end mark;
  - bit 46 enables the primitive write;
  - bits 57:47 are the primitive value;
  - bits 59:58 are the mode, where 0 is packed and 1, 2 and 3 are unsupported;
  - bits 63:60 are the descriptor count, where 0 means 16;
  - bits 127:64 hold the descriptors, with descriptor k in bits 64+4k+3:64+4k.
- R3: A header with loop count 0 is followed directly by the next header. No data quadword is read for it.
- R4: The descriptor index starts at 0 and advances on every consumed data quadword. After the last descriptor it wraps to 0 and the loop count drops by one. The body ends when the loop count reaches 0.
- R5: When the primitive enable is set in a packed header, one write to address 0x00 is issued before any data is read. Its data is the 11-bit primitive value, zero-extended, and the input is held (in_ready 0) until that write is taken.
- R6: Descriptor 2 writes address 0x02 with quadword bits 63:0 and keeps bits 95:64 as a held Q value. Descriptor 1 writes address 0x01 with data {Q, byte at bit 96, byte at bit 64, byte at bit 32, byte at bit 0}. Q is 0x3F800000 after reset.
- R7: Descriptor 4 writes {bits 107:100, bits 91:68, bits 47:32, bits 15:0} to address 0x04. If bit 111 is set, the write goes to address 0x0C instead. Descriptor 0xC always writes this value to address 0x0C. wr_nokick is 1 exactly on valid writes to 0x0C or 0x0D.
- R8: Descriptor 5 writes {bits 95:64, bits 47:32, bits 15:0} to address 0x05. If bit 111 is set, the write goes to address 0x0D instead. Descriptor 0xD always writes this value to address 0x0D.
- R9: Each of the following descriptors writes one register:
  - descriptor 3 writes address 0x03 with V (bits 45:32) in data bits 29:16 and U (bits 13:0) in data bits 13:0, all other bits 0;
  - descriptor 0 writes address 0x00 with bits 10:0;
  - descriptors 6 to 9 write their own number as the address, with bits 63:0;
  - descriptor 0xA writes address 0x0A with bits 107:100 placed in data bits 63:56.
- R10: Descriptor 0xE writes bits 63:0 to the address found in quadword bits 71:64.
- R11: Descriptors 0xF and 0xB consume their quadword and issue no write.
- R12: While wr_ready is 0, a pending write keeps wr_valid, wr_addr and wr_data steady and in_ready stays 0.
- R13: pkt_done is 1 in the cycle in which the last quadword or write of a packet with the end mark is taken. It stays 0 for packets without the end mark.
- R14: A header whose mode is not packed gives a one-cycle mode_unsup pulse when it is taken. The primitive enable is then ignored, and as many quadwords as the loop count are dropped with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input quadword valid |
| in_ready | output | 1 | Input quadword accepted when high with in_valid |
| in_qw | input | 128 | Input quadword |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Register write accepted |
| wr_addr | output | 8 | Register address |
| wr_data | output | 64 | Register data |
| wr_nokick | output | 1 | Vertex write that does not start drawing |
| pkt_done | output | 1 | End-marked packet completes this cycle |
| mode_unsup | output | 1 | Header with an unsupported mode taken this cycle |

## Verification
Some internal faults show at the ports on the very next quadword. A wrong descriptor index or a wrong wrap point shows as a write to an unexpected address. A wrong loop count shows as a pkt_done pulse that comes early or late, or as a later header that is read as data and gives stray writes. A stale Q register only shows on the first colour write after a texture-coordinate write, so the vectors put the two back to back in two loops. A stuck state after a primitive write or after a dropped packet shows within one quadword, as a wrong in_ready or wr_valid.

// File: rtl/gcp_pkg.sv
package gcp_pkg;
  localparam int QW_W    = 128;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 64;
  localparam int LOOP_W  = 15;
  localparam int DESC_W  = 4;
  localparam int NREG_W  = DESC_W + 1;
  localparam int PRIM_W  = 11;
  localparam int NDESC   = 1 << DESC_W;
  localparam int LIST_W  = NDESC * DESC_W;

  localparam logic [1:0] MODE_PACKED = 2'd0;

  localparam logic [ADDR_W-1:0] ADDR_PRIM  = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_COLOR = 8'h01;
  localparam logic [ADDR_W-1:0] ADDR_TEXST = 8'h02;
  localparam logic [ADDR_W-1:0] ADDR_TEXUV = 8'h03;
  localparam logic [ADDR_W-1:0] ADDR_VTXF  = 8'h04;
  localparam logic [ADDR_W-1:0] ADDR_VTX   = 8'h05;
  localparam logic [ADDR_W-1:0] ADDR_FOGV  = 8'h0A;
  localparam logic [ADDR_W-1:0] ADDR_VTXFN = 8'h0C;
  localparam logic [ADDR_W-1:0] ADDR_VTXN  = 8'h0D;

  localparam logic [31:0] Q_RESET = 32'h3F80_0000;

  typedef enum logic [DESC_W-1:0] {
    D_PRIM  = 4'h0, D_COLOR = 4'h1, D_TEXST = 4'h2, D_TEXUV = 4'h3,
    D_VTXF  = 4'h4, D_VTX   = 4'h5, D_GEN6  = 4'h6, D_GEN7  = 4'h7,
    D_GEN8  = 4'h8, D_GEN9  = 4'h9, D_FOGV  = 4'hA, D_RSVD  = 4'hB,
    D_VTXFN = 4'hC, D_VTXN  = 4'hD, D_ADDAT = 4'hE, D_SKIP  = 4'hF
  } desc_e;

  typedef enum logic [1:0] {ST_HDR, ST_PRIM, ST_BODY, ST_DROP} state_e;

  typedef struct packed {
    logic [LOOP_W-1:0] nloop;
    logic              eop;
    logic              pre;
    logic [PRIM_W-1:0] prim;
    logic [1:0]        mode;
    logic [NREG_W-1:0] nreg;
    logic [LIST_W-1:0] list;
  } hdr_t;
endpackage

// File: rtl/gcp_hdr_decode.sv
module gcp_hdr_decode
  import gcp_pkg::*;
(
  input  logic [QW_W-1:0] qw,
  output hdr_t            hdr
);
  logic [DESC_W-1:0] cnt_raw;
  logic              unused_hdr;

  assign cnt_raw = qw[63:60];

  always_comb begin
    hdr.nloop = qw[LOOP_W-1:0];
    hdr.eop   = qw[15];
    hdr.pre   = qw[46];
    hdr.prim  = qw[57:47];
    hdr.mode  = qw[59:58];
    // a zero count selects the full list
    hdr.nreg  = (cnt_raw == '0) ? NREG_W'(NDESC) : {1'b0, cnt_raw};
    hdr.list  = qw[64 +: LIST_W];
  end

  assign unused_hdr = ^qw[45:16];
endmodule

// File: rtl/gcp_seq.sv
module gcp_seq #(
  parameter int LOOP_W = 15,
  parameter int IDX_W  = 4,
  localparam int NREG_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LOOP_W-1:0] ld_loop,
  input  logic [NREG_W-1:0] ld_nreg,
  input  logic              step,
  output logic [IDX_W-1:0]  idx,
  output logic              loop_zero,
  output logic              last
);
  localparam logic [LOOP_W-1:0] LOOP_ONE = LOOP_W'(1);
  localparam logic [NREG_W-1:0] NREG_ONE = NREG_W'(1);

  logic [LOOP_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [NREG_W-1:0] nreg_q, nreg_d;
  logic              wrap;

  assign wrap      = ({1'b0, idx_q} == (nreg_q - NREG_ONE));
  assign last      = (cnt_q == LOOP_ONE) && wrap;
  assign loop_zero = (cnt_q == '0);
  assign idx       = idx_q;

  always_comb begin
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    nreg_d = nreg_q;
    if (load) begin
      cnt_d  = ld_loop;
      idx_d  = '0;
      nreg_d = ld_nreg;
    end else if (step) begin
      if (wrap) begin
        idx_d = '0;
        cnt_d = cnt_q - LOOP_ONE;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      nreg_q <= NREG_ONE;
    end else if (load || step) begin
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      nreg_q <= nreg_d;
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> ({1'b0, idx_q} < nreg_q)); // R4
  AST_LOOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !wrap) |=> (cnt_q == $past(cnt_q)) && (idx_q != '0)); // R4
endmodule

// File: rtl/gcp_fmt.sv
module gcp_fmt
  import gcp_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  input  logic [QW_W-1:0]   qw,
  input  logic [31:0]       q_held,
  output logic              emit,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              nokick,
  output logic              is_st
);
  logic              skip_bit;
  logic [DATA_W-1:0] vtxf_val;
  logic [DATA_W-1:0] vtx_val;
  logic              unused_fmt;

  assign skip_bit = qw[111];
  assign vtxf_val = {qw[107:100], qw[91:68], qw[47:32], qw[15:0]};
  assign vtx_val  = {qw[95:64], qw[47:32], qw[15:0]};

  always_comb begin
    emit  = 1'b1;
    addr  = ADDR_PRIM;
    data  = qw[DATA_W-1:0];
    is_st = 1'b0;
    case (desc_e'(desc))
      D_PRIM:  data = DATA_W'(qw[PRIM_W-1:0]);
      D_COLOR: begin
        addr = ADDR_COLOR;
        data = {q_held, qw[103:96], qw[71:64], qw[39:32], qw[7:0]};
      end
      D_TEXST: begin
        addr  = ADDR_TEXST;
        is_st = 1'b1;
      end
      D_TEXUV: begin
        addr = ADDR_TEXUV;
        data = {32'h0, 2'b00, qw[45:32], 2'b00, qw[13:0]};
      end
      D_VTXF: begin
        addr = skip_bit ? ADDR_VTXFN : ADDR_VTXF;
        data = vtxf_val;
      end
      D_VTX: begin
        addr = skip_bit ? ADDR_VTXN : ADDR_VTX;
        data = vtx_val;
      end
      D_GEN6, D_GEN7, D_GEN8, D_GEN9: addr = ADDR_W'(desc);
      D_FOGV: begin
        addr = ADDR_FOGV;
        data = {qw[107:100], 56'h0};
      end
      D_VTXFN: begin
        addr = ADDR_VTXFN;
        data = vtxf_val;
      end
      D_VTXN: begin
        addr = ADDR_VTXN;
        data = vtx_val;
      end
      D_ADDAT: addr = qw[71:64];
      default: emit = 1'b0;
    endcase
    nokick = emit && ((addr == ADDR_VTXFN) || (addr == ADDR_VTXN));
  end

  assign unused_fmt = ^qw;
endmodule

// File: rtl/gcp_unpacker.sv
module gcp_unpacker
  import gcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [QW_W-1:0]   in_qw,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_nokick,
  output logic              pkt_done,
  output logic              mode_unsup
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  hdr_t              hdr;
  state_e            st_q, st_d;
  logic              eop_q, eop_d;
  logic [PRIM_W-1:0] prim_q, prim_d;
  logic [LIST_W-1:0] list_q, list_d;
  logic [31:0]       qv_q, qv_d;

  logic              seq_load, seq_step, seq_zero, seq_last;
  logic [DESC_W-1:0] seq_idx;
  logic [NREG_W-1:0] ld_nreg;
  logic [DESC_W-1:0] cur_desc;

  logic              f_emit, f_nk, f_st;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data;

  gcp_hdr_decode u_hdr (.qw(in_qw), .hdr(hdr));

  gcp_seq #(.LOOP_W(LOOP_W), .IDX_W(DESC_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_ok),
    .load     (seq_load),
    .ld_loop  (hdr.nloop),
    .ld_nreg  (ld_nreg),
    .step     (seq_step),
    .idx      (seq_idx),
    .loop_zero(seq_zero),
    .last     (seq_last)
  );

  assign cur_desc = list_q[{seq_idx, 2'b00} +: DESC_W];

  gcp_fmt u_fmt (
    .desc  (cur_desc),
    .qw    (in_qw),
    .q_held(qv_q),
    .emit  (f_emit),
    .addr  (f_addr),
    .data  (f_data),
    .nokick(f_nk),
    .is_st (f_st)
  );

  always_comb begin
    st_d       = st_q;
    eop_d      = eop_q;
    prim_d     = prim_q;
    list_d     = list_q;
    qv_d       = qv_q;
    in_ready   = 1'b0;
    wr_valid   = 1'b0;
    wr_addr    = f_addr;
    wr_data    = f_data;
    wr_nokick  = 1'b0;
    pkt_done   = 1'b0;
    mode_unsup = 1'b0;
    seq_load   = 1'b0;
    seq_step   = 1'b0;
    ld_nreg    = hdr.nreg;
    case (st_q)
      ST_HDR: begin
        in_ready = rst_ok;
        if (in_valid && rst_ok) begin
          seq_load = 1'b1;
          eop_d    = hdr.eop;
          prim_d   = hdr.prim;
          list_d   = hdr.list;
          if (hdr.mode != MODE_PACKED) begin
            mode_unsup = 1'b1;
            ld_nreg    = NREG_W'(1);
            if (hdr.nloop == '0) pkt_done = hdr.eop;
            else                 st_d     = ST_DROP;
          end else if (hdr.pre) begin
            st_d = ST_PRIM;
          end else if (hdr.nloop == '0) begin
            pkt_done = hdr.eop;
          end else begin
            st_d = ST_BODY;
          end
        end
      end
      ST_PRIM: begin
        wr_valid = 1'b1;
        wr_addr  = ADDR_PRIM;
        wr_data  = DATA_W'(prim_q);
        if (wr_ready) begin
          if (seq_zero) begin
            pkt_done = eop_q;
            st_d     = ST_HDR;
          end else begin
            st_d = ST_BODY;
          end
        end
      end
      ST_BODY: begin
        in_ready  = !f_emit || wr_ready;
        wr_valid  = in_valid && f_emit;
        wr_nokick = wr_valid && f_nk;
        if (in_valid && in_ready) begin
          seq_step = 1'b1;
          if (f_st) qv_d = in_qw[95:64];
          if (seq_last) begin
            pkt_done = eop_q;
            st_d     = ST_HDR;
          end
        end
      end
      default: begin
        in_ready = 1'b1;
        if (in_valid) begin
          seq_step = 1'b1;
          if (seq_last) begin
            pkt_done = eop_q;
            st_d     = ST_HDR;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      st_q   <= ST_HDR;
      eop_q  <= 1'b0;
      prim_q <= '0;
      list_q <= '0;
      qv_q   <= Q_RESET;
    end else begin
      st_q <= st_d;
      if (seq_load) begin
        eop_q  <= eop_d;
        prim_q <= prim_d;
        list_q <= list_d;
      end
      if (seq_step) qv_q <= qv_d;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_ok |-> !in_ready && !wr_valid && !pkt_done && !mode_unsup); // R1
  AST_PRIM_FIRST: assert property (@(posedge clk) disable iff (!rst_ok)
    (st_q == ST_PRIM) |-> wr_valid && !in_ready && (wr_addr == ADDR_PRIM)); // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_valid && !wr_ready && in_valid && (st_q == ST_BODY)) |-> !in_ready); // R12
  AST_NOKICK_ADDR: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_valid && wr_nokick) |-> ((wr_addr == ADDR_VTXFN) || (wr_addr == ADDR_VTXN))); // R7
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_ok)
    (st_q == ST_DROP) |-> !wr_valid); // R14
  AST_DONE_TO_HDR: assert property (@(posedge clk) disable iff (!rst_ok)
    pkt_done |=> (st_q == ST_HDR)); // R13
endmodule

// File: tb/gcp_unpacker_tb.sv
module gcp_unpacker_tb;
  typedef struct packed {
    logic [127:0] qw;
    logic         rdy;
    logic         wv;
    logic [7:0]   addr;
    logic [63:0]  data;
    logic         nk;
    logic         dn;
    logic         ux;
    logic [7:0]   req;
  } vec_t;

  function automatic logic [127:0] mk_hdr(int nloop, bit eop, bit pre, int prim, int mode,
                                          int nreg, logic [63:0] list);
    logic [127:0] h;
    h = '0;
    h[14:0]   = nloop[14:0];
    h[15]     = eop;
    h[46]     = pre;
    h[57:47]  = prim[10:0];
    h[59:58]  = mode[1:0];
    h[63:60]  = nreg[3:0];
    h[127:64] = list;
    return h;
  endfunction

  function automatic logic [127:0] mk_xyzf(logic [15:0] x, logic [15:0] y, logic [23:0] z,
                                           logic [7:0] f, bit skip);
    logic [127:0] q;
    q = '0;
    q[15:0] = x; q[47:32] = y; q[91:68] = z; q[107:100] = f; q[111] = skip;
    return q;
  endfunction

  function automatic logic [127:0] mk_xyz(logic [15:0] x, logic [15:0] y, logic [31:0] z, bit skip);
    logic [127:0] q;
    q = '0;
    q[15:0] = x; q[47:32] = y; q[95:64] = z; q[111] = skip;
    return q;
  endfunction

  function automatic logic [127:0] mk_rgba(logic [7:0] r, logic [7:0] g, logic [7:0] b, logic [7:0] a);
    return {24'h0, a, 24'h0, b, 24'h0, g, 24'h0, r};
  endfunction

  function automatic vec_t mk_v(logic [127:0] qw, bit rdy, bit wv, logic [7:0] a, logic [63:0] d,
                                bit nk, bit dn, bit ux, int req);
    vec_t v;
    v.qw = qw; v.rdy = rdy; v.wv = wv; v.addr = a; v.data = d;
    v.nk = nk; v.dn = dn; v.ux = ux; v.req = req[7:0];
    return v;
  endfunction

  localparam logic [127:0] QW_FOG = {20'h0, 8'h5A, 100'h0};
  localparam logic [127:0] QW_UV  = {80'h0, 16'hD555, 16'h0, 16'hFFFF};

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    // packet A: primitive first, then ST / colour / vertex over two loops
    mk_v(mk_hdr(2, 0, 1, 'h123, 0, 3, 64'h412), 1, 0, 8'h00, 64'h0, 0, 0, 0, 2),                        // R2
    mk_v({32'h0, 32'h4000_0000, 32'h2222_2222, 32'h1111_1111}, 0, 1, 8'h00, 64'h123, 0, 0, 0, 5),      // R5
    mk_v({32'h0, 32'h4000_0000, 32'h2222_2222, 32'h1111_1111}, 1, 1, 8'h02, 64'h2222_2222_1111_1111, 0, 0, 0, 6), // R6
    mk_v(mk_rgba(8'h10, 8'h20, 8'h30, 8'h40), 1, 1, 8'h01, 64'h4000_0000_4030_2010, 0, 0, 0, 6),     // R6
    mk_v(mk_xyzf(16'h1234, 16'h5678, 24'hABCDEF, 8'h99, 0), 1, 1, 8'h04, 64'h99AB_CDEF_5678_1234, 0, 0, 0, 7), // R7
    mk_v({32'h0, 32'h3F00_0000, 32'h2, 32'h1}, 1, 1, 8'h02, 64'h0000_0002_0000_0001, 0, 0, 0, 4),     // R4
    mk_v(mk_rgba(8'h01, 8'h02, 8'h03, 8'h04), 1, 1, 8'h01, 64'h3F00_0000_0403_0201, 0, 0, 0, 6),     // R6
    mk_v(mk_xyzf(16'h1, 16'h2, 24'h3, 8'h4, 1), 1, 1, 8'h0C, 64'h0400_0003_0002_0001, 1, 0, 0, 7),   // R7 R13
    // packet B: skip vertex, UV, address+data, NOP, end mark
    mk_v(mk_hdr(1, 1, 0, 0, 0, 4, 64'hFE35), 1, 0, 8'h00, 64'h0, 0, 0, 0, 2),                          // R2
    mk_v(mk_xyz(16'hAAAA, 16'hBBBB, 32'hCCCC_DDDD, 1), 1, 1, 8'h0D, 64'hCCCC_DDDD_BBBB_AAAA, 1, 0, 0, 8), // R8
    mk_v(QW_UV, 1, 1, 8'h03, 64'h0000_0000_1555_3FFF, 0, 0, 0, 9),                                    // R9
    mk_v({56'h0, 8'h4C, 64'hDEAD_BEEF_0123_4567}, 1, 1, 8'h4C, 64'hDEAD_BEEF_0123_4567, 0, 0, 0, 10), // R10
    mk_v({128{1'b1}}, 1, 0, 8'h00, 64'h0, 0, 1, 0, 11),                                                // R11 R13
    // packet C: primitive only, zero loop count
    mk_v(mk_hdr(0, 1, 1, 'h7FF, 0, 1, 64'h0), 1, 0, 8'h00, 64'h0, 0, 0, 0, 3),                         // R3
    mk_v(mk_hdr(0, 1, 0, 0, 0, 1, 64'h0), 0, 1, 8'h00, 64'h7FF, 0, 1, 0, 5),                           // R5
    // packet D: empty packet
    mk_v(mk_hdr(0, 1, 0, 0, 0, 1, 64'h0), 1, 0, 8'h00, 64'h0, 0, 1, 0, 3),                             // R3
    // packet G: pass-through, reserved descriptor, fog
    mk_v(mk_hdr(1, 0, 0, 0, 0, 3, 64'hAB6), 1, 0, 8'h00, 64'h0, 0, 0, 0, 2),                           // R2
    mk_v({64'h0, 64'h1122_3344_5566_7788}, 1, 1, 8'h06, 64'h1122_3344_5566_7788, 0, 0, 0, 9),        // R9
    mk_v({64'h0, 64'h1122_3344_5566_7788}, 1, 0, 8'h00, 64'h0, 0, 0, 0, 11),                          // R11
    mk_v(QW_FOG, 1, 1, 8'h0A, 64'h5A00_0000_0000_0000, 0, 0, 0, 9),                                    // R9
    // packet E: unsupported mode, primitive enable ignored
    mk_v(mk_hdr(2, 1, 1, 5, 2, 1, 64'h0), 1, 0, 8'h00, 64'h0, 0, 0, 1, 14),                            // R14
    mk_v({64'h0, 56'h0, 8'hE0}, 1, 0, 8'h00, 64'h0, 0, 0, 0, 14),                                     // R14
    mk_v(mk_hdr(0, 0, 1, 1, 0, 1, 64'h0), 1, 0, 8'h00, 64'h0, 0, 1, 0, 14)                            // R14
  };

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] in_qw;
  logic         wr_valid;
  logic         wr_ready;
  logic [7:0]   wr_addr;
  logic [63:0]  wr_data;
  logic         wr_nokick;
  logic         pkt_done;
  logic         mode_unsup;

  int n_chk;
  int n_fail;

  gcp_unpacker u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_qw     (in_qw),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_nokick (wr_nokick),
    .pkt_done  (pkt_done),
    .mode_unsup(mode_unsup)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(bit ok, string req, string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  task automatic drive(logic v, logic [127:0] q, logic r);
    @(negedge clk);
    in_valid = v;
    in_qw    = q;
    wr_ready = r;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk    = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    in_valid = 1'b1;
    in_qw    = mk_hdr(1, 1, 1, 1, 0, 1, 64'hE);
    wr_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: quiet during reset with a quadword presented
    chk(!in_ready && !wr_valid && !pkt_done && !mode_unsup, "R1",
        $sformatf("act rdy=%b wv=%b dn=%b ux=%b exp 0 0 0 0", in_ready, wr_valid, pkt_done, mode_unsup));
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      bit ok;
      drive(1'b1, VECS[i].qw, 1'b1);
      ok = (in_ready == VECS[i].rdy) && (wr_valid == VECS[i].wv) && (pkt_done == VECS[i].dn) &&
           (mode_unsup == VECS[i].ux) && (wr_nokick == VECS[i].nk) &&
           (!VECS[i].wv || ((wr_addr == VECS[i].addr) && (wr_data == VECS[i].data)));
      chk(ok, $sformatf("R%0d", VECS[i].req),
          $sformatf("vec %0d act rdy=%b wv=%b a=%h d=%h nk=%b dn=%b ux=%b exp rdy=%b wv=%b a=%h d=%h nk=%b dn=%b ux=%b",
                    i, in_ready, wr_valid, wr_addr, wr_data, wr_nokick, pkt_done, mode_unsup,
                    VECS[i].rdy, VECS[i].wv, VECS[i].addr, VECS[i].data, VECS[i].nk, VECS[i].dn, VECS[i].ux));
    end

    // R12: write held while the register port stalls
    drive(1'b1, mk_hdr(1, 1, 0, 0, 0, 1, 64'hE), 1'b1);
    for (int k = 0; k < 2; k++) begin
      drive(1'b1, {56'h0, 8'h42, 64'h0BAD_CAFE_0000_0042}, 1'b0);
      chk(!in_ready && wr_valid && wr_addr == 8'h42 && wr_data == 64'h0BAD_CAFE_0000_0042 && !pkt_done,
          "R12", $sformatf("act rdy=%b wv=%b a=%h d=%h dn=%b exp 0 1 42 0badcafe00000042 0",
                           in_ready, wr_valid, wr_addr, wr_data, pkt_done));
    end
    drive(1'b1, {56'h0, 8'h42, 64'h0BAD_CAFE_0000_0042}, 1'b1);
    chk(in_ready && wr_valid && pkt_done, "R12",
        $sformatf("act rdy=%b wv=%b dn=%b exp 1 1 1", in_ready, wr_valid, pkt_done));

    // R2 R4: count field 0 selects sixteen descriptors
    drive(1'b1, mk_hdr(1, 1, 0, 0, 0, 0, 64'hEFFF_FFFF_FFFF_FFFF), 1'b1);
    for (int k = 0; k < 15; k++) begin
      drive(1'b1, {56'h0, 8'h77, 64'h1}, 1'b1);
      chk(in_ready && !wr_valid && !pkt_done, "R4",
          $sformatf("nop %0d act rdy=%b wv=%b dn=%b exp 1 0 0", k, in_ready, wr_valid, pkt_done));
    end
    drive(1'b1, {56'h0, 8'h77, 64'h1}, 1'b1);
    chk(wr_valid && wr_addr == 8'h77 && wr_data == 64'h1 && pkt_done, "R2",
        $sformatf("act wv=%b a=%h d=%h dn=%b exp 1 77 1 1", wr_valid, wr_addr, wr_data, pkt_done));

    drive(1'b0, '0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule